// File: doc/BRIEF.md
# PWM Sound Sequencer

The block builds one sound line out of a bank of PWM channel signals that other logic produces. Two channel selectors each choose one input. The first selector supplies a tone of fixed frequency whose duty cycle varies. The second supplies a fixed-duty signal whose frequency varies. A mode bit decides how the two are used:

- In mono mode the two selected signals are ANDed.
- In poly mode the first selection passes on alone.

The result goes through a gate and is registered onto the output pin.

Playback is started by software. It first writes the duration and the high and low phase lengths, then writes a nonzero play code. There is no start bit. The block compares the play code with its value one cycle earlier, and any difference restarts the sequencer.

- In the timed codes a countdown limits the length of the sound. When the countdown ends, the sound is held off and a sticky done flag is set. The flag is set whether or not the interrupt is enabled.
- In the gated codes the sound is switched on and off in alternating phases.
- The interrupt line is the done flag qualified by an enable bit.

Top module: `sound_gen_ctl`

## Requirements
- R1: The configuration register (address 0) holds selector A in bits [3:0], selector B in bits [7:4], the mono bit in bit 8, the interrupt enable in bit 9 and the play code in bits [12:10]. Selector k picks PWM input k.
- R2: When the mono bit is 1 the sound is `pwm_in[A] & pwm_in[B]`. When it is 0 the sound is `pwm_in[A]`. A change of selector or mono bit written at edge E appears on `snd_out` after edge E+1.
- R3: A play code written at edge E0 takes effect after edge E1, and `snd_out` first shows the new behaviour after edge E2. Writing the same code again does not restart playback.
- R4: Code 001 plays continuously. Code 000 and codes 101, 110 and 111 are idle, and in idle `snd_out` is 0.
- R5: Code 010 plays for D cycles, where D is the duration register at address 1. With D = 0 nothing is played. After expiry `snd_out` stays 0 until the play code changes.
- R6: The done flag (`done_flag`) rises at edge E1+max(D,1) in a timed code. It is set regardless of the interrupt enable. Writing a value with bit 0 set to the status address 4 clears the flag. Writing bit 0 as 0 leaves it set.
- R7: `irq` is 1 exactly when the done flag and the interrupt enable are both 1.
- R8: Code 011 plays continuously, gated on for H cycles and then off for L cycles, repeating and starting with the on phase. H is the register at address 2 and L the register at address 3. A length of 0 acts as 1.
- R9: Code 100 combines the R8 gating with the R5 countdown. Sample k counts from the first output sample, and sound is present only when k < D and (k mod (H+L)) < H.
- R10: After reset `snd_out`, `irq` and `done_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | NCH | PWM channel signals |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| snd_out | output | 1 | Registered sound output |
| irq | output | 1 | Interrupt request |
| done_flag | output | 1 | Sticky countdown-done flag |

## Verification
A selector or combine fault shows on `snd_out` one cycle after the configuration write. It is caught by sweeping every selector pair in both mono and poly mode against known input patterns.

A fault in the change detector or in the countdown moves the edges of the sound burst or of the flag by whole cycles. Every timed run is therefore compared sample by sample, starting two cycles after the write. A stuck phase counter in the gated codes breaks the on/off pattern within one period of H+L cycles.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   typedef enum logic [2:0] {
      PLAY_IDLE   = 3'd0,
      PLAY_CONT   = 3'd1,
      PLAY_TIMED  = 3'd2,
      PLAY_CGATE  = 3'd3,
      PLAY_TGATE  = 3'd4
   } play_e;

   localparam int ADR_CFG    = 0;
   localparam int ADR_DUR    = 1;
   localparam int ADR_HI     = 2;
   localparam int ADR_LO     = 3;
   localparam int ADR_STAT   = 4;

   localparam int CFG_SELA_LSB = 0;
   localparam int CFG_SELB_LSB = 4;
   localparam int CFG_MONO     = 8;
   localparam int CFG_IEN      = 9;
   localparam int CFG_PLAY_LSB = 10;

   function automatic logic play_active(input logic [2:0] c);
      return (c == PLAY_CONT) || (c == PLAY_TIMED) || (c == PLAY_CGATE) || (c == PLAY_TGATE);
   endfunction

   function automatic logic play_timed(input logic [2:0] c);
      return (c == PLAY_TIMED) || (c == PLAY_TGATE);
   endfunction

   function automatic logic play_gated(input logic [2:0] c);
      return (c == PLAY_CGATE) || (c == PLAY_TGATE);
   endfunction

endpackage

// File: rtl/sgc_chan_mux.sv
module sgc_chan_mux #(
   parameter int NCH   = 16,
   parameter int SEL_W = 4
) (
   input  logic [NCH-1:0]   ch_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             sig_o
);

   localparam int SPAN = 1 << SEL_W;

   generate
      if (NCH < 1 || NCH > SPAN) begin : g_bad
         $error("sgc_chan_mux: NCH must lie in 1..2**SEL_W");
      end

      if (NCH == SPAN) begin : g_full
         assign sig_o = ch_i[sel_i];
      end else begin : g_part
         always_comb begin
            sig_o = 1'b0;
            for (int i = 0; i < NCH; i++) begin
               if (sel_i == SEL_W'(i)) sig_o = ch_i[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sgc_seq.sv
module sgc_seq
   import sgc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       play_i,
   input  logic [CNT_W-1:0] dur_i,
   input  logic [CNT_W-1:0] hi_i,
   input  logic [CNT_W-1:0] lo_i,
   output logic             gate_o,
   output logic             expire_o,
   output logic             running_o,
   output logic             expired_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [2:0]       play_d1;
   logic [2:0]       run_code;
   logic [CNT_W-1:0] dur_cnt;
   logic [CNT_W-1:0] ph_cnt;
   logic             ph_on;
   logic             expired_q;
   logic             chg;
   logic             timed;
   logic             gated;

   assign chg       = (play_i != play_d1);
   assign running_o = play_active(run_code);
   assign timed     = play_timed(run_code);
   assign gated     = play_gated(run_code);
   assign expired_o = expired_q;

   assign expire_o = running_o && timed && !expired_q && !chg && (dur_cnt <= ONE);

   assign gate_o = running_o
                 && (!timed || (!expired_q && dur_cnt != '0))
                 && (!gated || ph_on);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         play_d1   <= '0;
         run_code  <= '0;
         dur_cnt   <= '0;
         ph_cnt    <= '0;
         ph_on     <= 1'b1;
         expired_q <= 1'b0;
      end else begin
         play_d1 <= play_i;
         if (chg) begin
            run_code  <= play_i;
            dur_cnt   <= dur_i;
            ph_cnt    <= hi_i;
            ph_on     <= 1'b1;
            expired_q <= 1'b0;
         end else if (running_o) begin
            if (timed && !expired_q) begin
               if (dur_cnt <= ONE) begin
                  dur_cnt   <= '0;
                  expired_q <= 1'b1;
               end else begin
                  dur_cnt <= dur_cnt - ONE;
               end
            end
            if (gated) begin
               if (ph_cnt <= ONE) begin
                  ph_on  <= !ph_on;
                  ph_cnt <= ph_on ? lo_i : hi_i;
               end else begin
                  ph_cnt <= ph_cnt - ONE;
               end
            end
         end
      end
   end

   // R5: an active countdown above one drops by exactly one
   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && timed && !expired_q && !chg && dur_cnt > ONE)
      |=> (dur_cnt == $past(dur_cnt) - ONE));

   // R8: a phase with cycles left keeps its polarity
   a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && gated && !chg && ph_cnt > ONE) |=> (ph_on == $past(ph_on)));

   // R5: once expired, stays expired until the code changes
   a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_q && !chg) |=> expired_q);

endmodule

// File: rtl/sound_gen_ctl.sv
module sound_gen_ctl
   import sgc_pkg::*;
#(
   parameter int NCH    = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    pwm_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              snd_out,
   output logic              irq,
   output logic              done_flag
);

   localparam int SEL_W = 4;

   generate
      if (DATA_W < CFG_PLAY_LSB + 3) begin : g_bad_dw
         $error("sound_gen_ctl: DATA_W too narrow for configuration fields");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cw
         $error("sound_gen_ctl: CNT_W must lie in 1..DATA_W");
      end
      if ((1 << ADDR_W) <= ADR_STAT) begin : g_bad_aw
         $error("sound_gen_ctl: ADDR_W too narrow for register map");
      end
   endgenerate

   logic [SEL_W-1:0] sel_a, sel_b;
   logic             mono_q, ien_q;
   logic [2:0]       play_q;
   logic [CNT_W-1:0] dur_q, hi_q, lo_q;
   logic             flag_q, snd_q;
   logic             sig_a, sig_b, mix;
   logic             gate, expire_evt, running, expired;
   logic             wr_cfg, wr_stat;

   assign wr_cfg  = wr_en && (wr_addr == ADDR_W'(ADR_CFG));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(ADR_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_a  <= '0;
         sel_b  <= '0;
         mono_q <= 1'b0;
         ien_q  <= 1'b0;
         play_q <= '0;
         dur_q  <= '0;
         hi_q   <= '0;
         lo_q   <= '0;
      end else if (wr_en) begin
         if (wr_cfg) begin
            sel_a  <= wr_data[CFG_SELA_LSB +: SEL_W];
            sel_b  <= wr_data[CFG_SELB_LSB +: SEL_W];
            mono_q <= wr_data[CFG_MONO];
            ien_q  <= wr_data[CFG_IEN];
            play_q <= wr_data[CFG_PLAY_LSB +: 3];
         end
         if (wr_addr == ADDR_W'(ADR_DUR)) dur_q <= wr_data[CNT_W-1:0];
         if (wr_addr == ADDR_W'(ADR_HI))  hi_q  <= wr_data[CNT_W-1:0];
         if (wr_addr == ADDR_W'(ADR_LO))  lo_q  <= wr_data[CNT_W-1:0];
      end
   end

   sgc_chan_mux #(.NCH(NCH), .SEL_W(SEL_W)) u_mux_a (
      .ch_i(pwm_in), .sel_i(sel_a), .sig_o(sig_a));

   sgc_chan_mux #(.NCH(NCH), .SEL_W(SEL_W)) u_mux_b (
      .ch_i(pwm_in), .sel_i(sel_b), .sig_o(sig_b));

   assign mix = mono_q ? (sig_a & sig_b) : sig_a;

   sgc_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .play_i(play_q),
      .dur_i(dur_q), .hi_i(hi_q), .lo_i(lo_q),
      .gate_o(gate), .expire_o(expire_evt),
      .running_o(running), .expired_o(expired));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         snd_q  <= 1'b0;
      end else begin
         snd_q <= gate & mix;
         if (expire_evt)                flag_q <= 1'b1;
         else if (wr_stat && wr_data[0]) flag_q <= 1'b0;
      end
   end

   assign snd_out   = snd_q;
   assign done_flag = flag_q;
   assign irq       = flag_q & ien_q;

   // R6: the flag only rises on a countdown expiry
   a_r6_flag_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(expire_evt));

   // R6: the flag is sticky without a clearing write
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(wr_stat && wr_data[0])) |=> flag_q);

   // R5: no sound follows an expired countdown
   a_r5_expired_silent: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !snd_q);

   // R4: no sound follows an idle sequencer
   a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> !snd_q);

endmodule

// File: tb/tb_sound_gen_ctl.sv
module tb_sound_gen_ctl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pwm_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        snd_out, irq, done_flag;

   int total = 0;
   int bad = 0;

   sound_gen_ctl dut (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .snd_out(snd_out), .irq(irq), .done_flag(done_flag));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Ends on the falling edge after the write edge.
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] cfg(input int sa, input int sb, input logic mono,
                                       input logic ien, input logic [2:0] code);
      return {3'b000, code, 1'b0 & ien, 9'd0} | 16'(ien) << 9 | 16'(mono) << 8
             | 16'(sb) << 4 | 16'(sa);
   endfunction

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Timed or gated run: pwm all ones, selector 0, poly mode
   task automatic run(input string req, input logic [2:0] code,
                      input int d, input int h, input int l, input int nsamp);
      int hh, ll, fk;
      logic timed, gated, e;
      hh = (h < 1) ? 1 : h;
      ll = (l < 1) ? 1 : l;
      timed = (code == 3'd2) || (code == 3'd4);
      gated = (code == 3'd3) || (code == 3'd4);
      fk = ((d < 1) ? 1 : d) - 1;
      pwm_in = 16'hFFFF;
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd0));
      settle(3);
      wr(3'd1, 16'(d));
      wr(3'd2, 16'(h));
      wr(3'd3, 16'(l));
      wr(3'd4, 16'h0001);
      check({req, " flag cleared before start"}, done_flag, 1'b0);
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, code));
      settle(1);
      for (int k = 0; k < nsamp; k++) begin
         @(negedge clk);
         e = (!timed || k < d) && (!gated || (k % (hh + ll)) < hh);
         check({req, " sound sample"}, snd_out, e);
         if (timed) check("R6 flag timing", done_flag, (k >= fk));
         else       check("R6 flag stays clear", done_flag, 1'b0);
         check("R7 irq with enable off", irq, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] pats [2];
      logic e;
      pats[0] = 16'hA5C3;
      pats[1] = 16'h3C96;
      repeat (3) @(negedge clk);
      check("R10 snd_out reset", snd_out, 1'b0);
      check("R10 irq reset", irq, 1'b0);
      check("R10 flag reset", done_flag, 1'b0);
      rst_n = 1'b1;
      settle(2);

      // R1 / R2 selector and combine sweep in continuous code
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd1));
      settle(2);
      for (int p = 0; p < 2; p++) begin
         pwm_in = pats[p];
         for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
               for (int b = 0; b < 16; b++) begin
                  wr(3'd0, cfg(a, b, m[0], 1'b0, 3'd1));
                  @(negedge clk);
                  e = m[0] ? (pats[p][a] & pats[p][b]) : pats[p][a];
                  check(m[0] ? "R2 mono AND of R1 selections" : "R1 poly selection A",
                        snd_out, e);
               end
            end
         end
      end

      // R3 / R4 stop on code 000: two cycles after the write
      pwm_in = 16'hFFFF;
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd1));
      settle(2);
      check("R4 continuous plays", snd_out, 1'b1);
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd0));
      check("R3 still on after write edge", snd_out, 1'b1);
      @(negedge clk);
      check("R3 still on after detect edge", snd_out, 1'b1);
      @(negedge clk);
      check("R3 R4 off after idle start", snd_out, 1'b0);

      // R4 undefined codes are idle
      for (int c = 5; c < 8; c++) begin
         wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'(c)));
         settle(4);
         check("R4 unused code silent", snd_out, 1'b0);
         wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd1));
         settle(1);
         check("R3 start not yet visible", snd_out, 1'b0);
         @(negedge clk);
         check("R3 start visible", snd_out, 1'b1);
         wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd0));
         settle(3);
      end

      // R3 rewrite of same code does not restart a timed run
      run("R5 timed D=4", 3'd2, 4, 0, 0, 8);
      wr(3'd0, cfg(0, 0, 1'b0, 1'b0, 3'd2));
      settle(3);
      check("R3 same code no restart", snd_out, 1'b0);

      // R5 timed durations, hold-off after expiry
      run("R5 timed D=0", 3'd2, 0, 0, 0, 6);
      run("R5 timed D=1", 3'd2, 1, 0, 0, 6);
      run("R5 timed D=2", 3'd2, 2, 0, 0, 8);
      run("R5 timed D=7", 3'd2, 7, 0, 0, 14);

      // R6 / R7 flag and interrupt
      check("R6 flag set with enable off", done_flag, 1'b1);
      check("R7 irq off while disabled", irq, 1'b0);
      wr(3'd0, cfg(0, 0, 1'b0, 1'b1, 3'd2));
      check("R7 irq on when enabled", irq, 1'b1);
      wr(3'd4, 16'h0000);
      check("R6 zero write keeps flag", done_flag, 1'b1);
      check("R7 irq still on", irq, 1'b1);
      wr(3'd4, 16'h0001);
      check("R6 one write clears flag", done_flag, 1'b0);
      check("R7 irq drops with flag", irq, 1'b0);
      check("R5 still silent after clear", snd_out, 1'b0);

      // R8 continuous gated
      run("R8 gated H=2 L=3", 3'd3, 0, 2, 3, 20);
      run("R8 gated H=1 L=1", 3'd3, 0, 1, 1, 10);
      run("R8 gated H=0 L=0 as 1", 3'd3, 0, 0, 0, 10);
      run("R8 gated H=3 L=1", 3'd3, 0, 3, 1, 16);

      // R9 timed gated
      run("R9 timed gated D=7 H=2 L=1", 3'd4, 7, 2, 1, 14);
      run("R9 timed gated D=10 H=3 L=2", 3'd4, 10, 3, 2, 16);
      run("R9 timed gated D=0", 3'd4, 0, 2, 2, 6);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule